// File: doc/BRIEF.md
# Synchronous Character Receiver with Hunt

This block takes a serial bit stream, one bit per receive strobe, and works out where characters begin before it frames any data. In internal mode it hunts bit by bit for a programmed sync pattern. In external mode it waits for an input pin that says the line is aligned. Once aligned, it assembles characters of 5 to 8 data bits, least significant bit first. An optional parity bit follows each character. Each finished character is placed in a holding register and a ready flag is raised for the host.

Software selects the character length, parity, sync source and sync pattern with static configuration inputs. An enter-hunt pulse drops alignment and starts the search again. The sync-detect, ready, parity-error and overrun flags can be read at any time. Reading the character pulses an acknowledge, and a separate pulse clears the two error flags.

Top module: `sync_char_rx`

## Requirements
- R1: After reset the receiver is hunting, and sync_det_o, rx_ready_o, parity_err_o, overrun_o and rx_char_o are all zero.
- R2: In internal mode (ext_sync_en_i low), sync_det_o rises after the bit strobe at which the last N received bits, taken oldest-first as bit 0, equal the low N bits of sync_char_i. Here N is the character length. A match counts only once at least N bits have arrived since the last hunt start.
- R3: In external mode (ext_sync_en_i high), sync_pin_i high while hunting sets sync_det_o one clock later, whatever the data. The pattern match does not apply in this mode.
- R4: hunt_i clears sync_det_o on the next clock and discards any partial character. Once aligned, the receiver stays aligned until hunt_i.
- R5: After alignment, the first bit strobe begins a character. A character is framed every N bits, or every N+1 bits with parity, and the data arrives least significant bit first.
- R6: char_len_i encodes the length as 0→5, 1→6, 2→7, 3→8 bits. Data bits at and above the length read as zero in rx_char_o.
- R7: With parity_en_i set, the bit after the data is parity. parity_odd_i=0 expects an even count of ones over data plus parity, and parity_odd_i=1 expects an odd count. A mismatch sets the sticky parity_err_o, and the character is still delivered.
- R8: A completed character sets rx_ready_o on the next clock. rd_ack_i clears rx_ready_o unless a character completes in the same cycle.
- R9: When a character completes while rx_ready_o is set and rd_ack_i is low, overrun_o is set (sticky). The new character replaces the held one.
- R10: err_clr_i clears parity_err_o and overrun_o and leaves rx_ready_o and rx_char_o unchanged.
- R11: Bit strobes that arrive while hunting never complete a character and never change rx_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_bit_en_i | input | 1 | Receive strobe: sample rx_data_i this clock |
| rx_data_i | input | 1 | Serial data in |
| char_len_i | input | 2 | Character length code (0..3 → 5..8 bits) |
| parity_en_i | input | 1 | Parity bit follows each character |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even |
| ext_sync_en_i | input | 1 | 1 = align on sync_pin_i, 0 = hunt for pattern |
| sync_pin_i | input | 1 | External alignment request |
| sync_char_i | input | 8 | Programmed sync pattern |
| hunt_i | input | 1 | Enter-hunt command pulse |
| rd_ack_i | input | 1 | Host has read rx_char_o |
| err_clr_i | input | 1 | Clear error flags |
| rx_char_o | output | 8 | Holding register |
| rx_ready_o | output | 1 | Character available |
| sync_det_o | output | 1 | Receiver is aligned |
| parity_err_o | output | 1 | Sticky parity error |
| overrun_o | output | 1 | Sticky overrun |

## Verification
Several behaviours are checked on every cycle by properties:
- an enter-hunt pulse always drops alignment, and alignment never drops without one;
- the external pin aligns the receiver on the next clock;
- no character completes while the receiver is hunting;
- a completed character always raises ready;
- a completion while ready is still set raises overrun;
- an error clear with no completion in the same cycle leaves both flags low;
- the upper bits of a short character read as zero.

The bench scenarios are needed to show the rest:
- the exact bit at which a pattern match fires, including the fill gate against a pattern of all zeros;
- least-significant-first assembly at 5, 7 and 8 bits;
- the polarity of even and odd parity;
- that a character cut short by a hunt is thrown away.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int MIN_LEN = 5;
  localparam int CNT_W   = $clog2(DATA_W + 2);

  typedef logic [LEN_W-1:0]  len_code_t;
  typedef logic [CNT_W-1:0]  bit_cnt_t;
  typedef logic [DATA_W-1:0] char_t;

  typedef enum logic {ST_HUNT = 1'b0, ST_SYNC = 1'b1} sync_state_t;

  function automatic bit_cnt_t char_bits(len_code_t c);
    return bit_cnt_t'(MIN_LEN) + bit_cnt_t'(c);
  endfunction

  function automatic bit_cnt_t pad_bits(len_code_t c);
    return bit_cnt_t'(DATA_W) - char_bits(c);
  endfunction

  function automatic char_t len_mask(len_code_t c);
    return {DATA_W{1'b1}} >> pad_bits(c);
  endfunction
endpackage

// File: rtl/sync_rx_hunt.sv
module sync_rx_hunt
  import sync_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      bit_i,
  input  len_code_t len_i,
  input  logic      ext_mode_i,
  input  logic      sync_pin_i,
  input  char_t     pattern_i,
  input  logic      hunt_i,
  output logic      in_sync_o
);
  sync_state_t state_q;
  char_t       win_q, win_nxt;
  bit_cnt_t    fill_q, fill_nxt;
  logic        pat_hit;

  always_comb begin
    win_nxt  = {bit_i, win_q[DATA_W-1:1]};
    fill_nxt = (fill_q >= bit_cnt_t'(DATA_W)) ? fill_q : fill_q + bit_cnt_t'(1);
    // newest N bits sit at the top of the window
    pat_hit  = ((win_nxt >> pad_bits(len_i)) == (pattern_i & len_mask(len_i)))
               && (fill_nxt >= char_bits(len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      win_q   <= '0;
      fill_q  <= '0;
    end else if (hunt_i) begin
      state_q <= ST_HUNT;
      win_q   <= '0;
      fill_q  <= '0;
    end else if (state_q == ST_HUNT) begin
      if (ext_mode_i) begin
        if (sync_pin_i) state_q <= ST_SYNC;
      end else if (bit_en_i) begin
        win_q  <= win_nxt;
        fill_q <= fill_nxt;
        if (pat_hit) state_q <= ST_SYNC;
      end
    end
  end

  assign in_sync_o = (state_q == ST_SYNC);

  assert_hunt_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> !in_sync_o);
  assert_sync_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync_o && !hunt_i) |=> in_sync_o);
  assert_ext_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sync_o && ext_mode_i && sync_pin_i && !hunt_i) |=> in_sync_o);
  assert_int_needs_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sync_o && !ext_mode_i && !bit_en_i) |=> !in_sync_o);
endmodule

// File: rtl/sync_rx_framer.sv
module sync_rx_framer
  import sync_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_sync_i,
  input  logic      hunt_i,
  input  logic      bit_en_i,
  input  logic      bit_i,
  input  len_code_t len_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output char_t     char_o,
  output logic      perr_o
);
  bit_cnt_t cnt_q, n_bits, frame_len;
  char_t    data_q, data_nxt;
  logic     par_q, par_nxt, take, last;

  always_comb begin
    n_bits    = char_bits(len_i);
    frame_len = n_bits + bit_cnt_t'(par_en_i);
    take      = bit_en_i && in_sync_i && !hunt_i;
    data_nxt  = (cnt_q < n_bits) ? {bit_i, data_q[DATA_W-1:1]} : data_q;
    par_nxt   = par_q ^ bit_i;
    last      = (cnt_q == frame_len - bit_cnt_t'(1));
    done_o    = take && last;
    char_o    = data_nxt >> pad_bits(len_i);
    perr_o    = done_o && par_en_i && (par_nxt != par_odd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (!in_sync_i || hunt_i) begin
      cnt_q  <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        cnt_q  <= '0;
        data_q <= '0;
        par_q  <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + bit_cnt_t'(1);
        data_q <= data_nxt;
        par_q  <= par_nxt;
      end
    end
  end

  assert_no_frame_hunting_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_sync_i);
  assert_cnt_idle_hunting_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sync_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sync_rx_hold.sv
module sync_rx_hold
  import sync_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  char_t     char_i,
  input  logic      perr_i,
  input  len_code_t len_i,
  input  logic      rd_ack_i,
  input  logic      err_clr_i,
  output char_t     data_o,
  output logic      ready_o,
  output logic      perr_o,
  output logic      ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      perr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (done_i) data_o <= char_i;

      if (done_i)        ready_o <= 1'b1;
      else if (rd_ack_i) ready_o <= 1'b0;

      if (done_i && ready_o && !rd_ack_i) ovr_o <= 1'b1;
      else if (err_clr_i)                 ovr_o <= 1'b0;

      if (done_i && perr_i) perr_o <= 1'b1;
      else if (err_clr_i)   perr_o <= 1'b0;
    end
  end

  assert_ready_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_i && !done_i) |=> !ready_o);
  assert_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rd_ack_i) |=> ovr_o);
  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !done_i) |=> (!ovr_o && !perr_o));
  assert_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $stable(len_i)) |=> ((data_o & ~len_mask(len_i)) == '0));
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_bit_en_i,
  input  logic       rx_data_i,
  input  logic [1:0] char_len_i,
  input  logic       parity_en_i,
  input  logic       parity_odd_i,
  input  logic       ext_sync_en_i,
  input  logic       sync_pin_i,
  input  logic [7:0] sync_char_i,
  input  logic       hunt_i,
  input  logic       rd_ack_i,
  input  logic       err_clr_i,
  output logic [7:0] rx_char_o,
  output logic       rx_ready_o,
  output logic       sync_det_o,
  output logic       parity_err_o,
  output logic       overrun_o
);
  logic  in_sync, done, perr;
  char_t frame_char;

  sync_rx_hunt u_hunt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (rx_bit_en_i),
    .bit_i      (rx_data_i),
    .len_i      (char_len_i),
    .ext_mode_i (ext_sync_en_i),
    .sync_pin_i (sync_pin_i),
    .pattern_i  (sync_char_i),
    .hunt_i     (hunt_i),
    .in_sync_o  (in_sync)
  );

  sync_rx_framer u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_sync_i (in_sync),
    .hunt_i    (hunt_i),
    .bit_en_i  (rx_bit_en_i),
    .bit_i     (rx_data_i),
    .len_i     (char_len_i),
    .par_en_i  (parity_en_i),
    .par_odd_i (parity_odd_i),
    .done_o    (done),
    .char_o    (frame_char),
    .perr_o    (perr)
  );

  sync_rx_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .char_i    (frame_char),
    .perr_i    (perr),
    .len_i     (char_len_i),
    .rd_ack_i  (rd_ack_i),
    .err_clr_i (err_clr_i),
    .data_o    (rx_char_o),
    .ready_o   (rx_ready_o),
    .perr_o    (parity_err_o),
    .ovr_o     (overrun_o)
  );

  assign sync_det_o = in_sync;

  assert_ready_needs_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_det_o && !rx_ready_o) |=> !rx_ready_o);
endmodule

// File: tb/sync_char_rx_test.sv
module sync_char_rx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_bit_en_i = 1'b0, rx_data_i = 1'b0;
  logic [1:0] char_len_i = 2'd3;
  logic       parity_en_i = 1'b0, parity_odd_i = 1'b0;
  logic       ext_sync_en_i = 1'b0, sync_pin_i = 1'b0;
  logic [7:0] sync_char_i = 8'h16;
  logic       hunt_i = 1'b0, rd_ack_i = 1'b0, err_clr_i = 1'b0;
  logic [7:0] rx_char_o;
  logic       rx_ready_o, sync_det_o, parity_err_o, overrun_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sync_char_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_bit_en_i(rx_bit_en_i), .rx_data_i(rx_data_i),
    .char_len_i(char_len_i), .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
    .ext_sync_en_i(ext_sync_en_i), .sync_pin_i(sync_pin_i), .sync_char_i(sync_char_i),
    .hunt_i(hunt_i), .rd_ack_i(rd_ack_i), .err_clr_i(err_clr_i),
    .rx_char_o(rx_char_o), .rx_ready_o(rx_ready_o), .sync_det_o(sync_det_o),
    .parity_err_o(parity_err_o), .overrun_o(overrun_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); rx_data_i = b; rx_bit_en_i = 1'b1;
    @(negedge clk); rx_bit_en_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_char(logic [7:0] d, int n, bit bad_par);
    logic p;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_bit(d[i]);
      p ^= d[i];
    end
    if (parity_en_i) send_bit(p ^ parity_odd_i ^ bad_par);
  endtask

  task automatic prep(logic [1:0] len, bit pe, bit odd, bit ext);
    char_len_i = len; parity_en_i = pe; parity_odd_i = odd; ext_sync_en_i = ext;
    pulse(hunt_i); pulse(rd_ack_i); pulse(err_clr_i);
  endtask

  task automatic sync_on_pattern(logic [7:0] pat, int n);
    sync_char_i = pat;
    for (int i = 0; i < n; i++) send_bit(pat[i]);
  endtask

  task automatic t_reset;
    chk("R1 sync_det", sync_det_o, 0);
    chk("R1 ready", rx_ready_o, 0);
    chk("R1 errors", {parity_err_o, overrun_o}, 0);
    chk("R1 data", rx_char_o, 0);
  endtask

  task automatic t_internal_8;
    logic [7:0] pat = 8'h16;
    prep(2'd3, 1'b0, 1'b0, 1'b0);
    sync_char_i = pat;
    send_bit(1); send_bit(1); send_bit(1);
    for (int i = 0; i < 7; i++) send_bit(pat[i]);
    chk("R2 no early sync", sync_det_o, 0);
    send_bit(pat[7]);
    chk("R2 sync on match", sync_det_o, 1);
    send_char(8'hA5, 8, 0);
    chk("R5 ready 8-bit", rx_ready_o, 1);
    chk("R5 data 8-bit lsb first", rx_char_o, 8'hA5);
    pulse(rd_ack_i);
    chk("R8 ack clears ready", rx_ready_o, 0);
  endtask

  task automatic t_zero_pattern_fill;
    prep(2'd3, 1'b0, 1'b0, 1'b0);
    sync_char_i = 8'h00;
    for (int i = 0; i < 7; i++) send_bit(0);
    chk("R2 fill gate", sync_det_o, 0);
    send_bit(0);
    chk("R2 sync after N bits", sync_det_o, 1);
  endtask

  task automatic t_len5_parity;
    prep(2'd0, 1'b1, 1'b0, 1'b0);
    sync_on_pattern(8'h16, 5);
    chk("R2 5-bit sync", sync_det_o, 1);
    send_char(8'h13, 5, 0);
    chk("R6 5-bit data", rx_char_o, 8'h13);
    chk("R7 even parity ok", parity_err_o, 0);
    pulse(rd_ack_i);
    send_char(8'hFF, 5, 0);
    chk("R6 upper bits zero", rx_char_o, 8'h1F);
    pulse(rd_ack_i);
    send_char(8'h0A, 5, 1);
    chk("R7 bad parity flagged", parity_err_o, 1);
    chk("R7 char still delivered", {rx_ready_o, rx_char_o}, {1'b1, 8'h0A});
    pulse(err_clr_i);
    chk("R10 parity cleared", parity_err_o, 0);
    chk("R10 ready kept", rx_ready_o, 1);
  endtask

  task automatic t_overrun;
    prep(2'd3, 1'b0, 1'b0, 1'b0);
    sync_on_pattern(8'h16, 8);
    send_char(8'h11, 8, 0);
    chk("R9 no overrun first", overrun_o, 0);
    send_char(8'h22, 8, 0);
    chk("R9 overrun set", overrun_o, 1);
    chk("R9 data replaced", rx_char_o, 8'h22);
    pulse(err_clr_i);
    chk("R10 overrun cleared", overrun_o, 0);
    chk("R10 data kept", {rx_ready_o, rx_char_o}, {1'b1, 8'h22});
    pulse(rd_ack_i);
  endtask

  task automatic t_hunt_cmd;
    prep(2'd3, 1'b0, 1'b0, 1'b0);
    sync_on_pattern(8'h16, 8);
    send_bit(1); send_bit(0); send_bit(1);
    pulse(hunt_i);
    chk("R4 hunt clears sync", sync_det_o, 0);
    for (int i = 0; i < 10; i++) send_bit(1);
    chk("R11 no char while hunting", rx_ready_o, 0);
    chk("R11 still hunting", sync_det_o, 0);
    sync_on_pattern(8'h16, 8);
    send_char(8'h3C, 8, 0);
    chk("R4 partial discarded", rx_char_o, 8'h3C);
    chk("R4 no overrun", overrun_o, 0);
    pulse(rd_ack_i);
  endtask

  task automatic t_external;
    prep(2'd2, 1'b1, 1'b1, 1'b1);
    sync_char_i = 8'h00;
    for (int i = 0; i < 9; i++) send_bit(0);
    chk("R3 no pattern sync", sync_det_o, 0);
    pulse(sync_pin_i);
    chk("R3 pin sync", sync_det_o, 1);
    send_char(8'h55, 7, 0);
    chk("R7 odd parity ok", parity_err_o, 0);
    chk("R6 7-bit data", rx_char_o, 8'h55);
    pulse(rd_ack_i);
    send_char(8'h03, 7, 1);
    chk("R7 odd parity bad", parity_err_o, 1);
    pulse(rd_ack_i);
    pulse(err_clr_i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_internal_8();
    t_zero_pattern_fill();
    t_len5_parity();
    t_overrun();
    t_hunt_cmd();
    t_external();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule